// File: doc/BRIEF.md
# Code-Driven Thread Access Guard

The guard sits beside a processor's load/store and branch paths and decides, in the same cycle, whether each data access and each control-transfer target is legal. A table of eight address regions maps every address to a link number. Links are split into code links and data links by a mask. The code link that holds the current program counter selects which permissions apply. No per-task state has to be rewritten when execution moves from one thread to another.

Data reads and writes are checked against a two-bit permission drawn from a square table indexed by the executing code link and the addressed data link. Calls, branches and returns are checked too. A target inside the current code link always passes. A target in another code link passes only if it equals one of that link's registered entry addresses. An accepted crossing switches the selected hardware stack to the new thread. Any refusal raises a one-cycle fault, and the next clock edge records the faulting address and its kind.

Top module: `thread_guard`

## Requirements
- R1: An address belongs to region r when base_r <= addr <= limit_r, both bounds inclusive. When several regions match, the lowest-numbered one decides the link. An address that matches no region has no link.
- R2: `active_link_o` shows the link of the region holding `pc_i`, or 0 when the PC matches no region. If a request arrives while the PC matches no region, or its link is not set in `cfg_code_mask_i`, the request is refused with a PC fault.
- R3: The permission for code link c on data link d is `cfg_perm_i[(c*8+d)*2 +: 2]`. Bit 0 grants read and bit 1 grants write, so 00 means no access, 01 read only, 10 write only and 11 read and write.
- R4: With a valid PC, a data access faults in the same cycle if its address matches no region or the permission bit for its direction is clear.
- R5: A transfer whose target lies in the current code link is allowed whatever its address within that link.
- R6: A transfer into a different link is allowed only if that link is a code link and the target equals an entry slot of that link whose valid bit is set. Slot e of link l is `cfg_entry_i[(l*2+e)*32 +: 32]`, and its valid bit is `cfg_entry_vld_i[l*2+e]`. A target that matches no region faults.
- R7: `stack_sel_o` resets to 0. It takes the target link on the edge after an accepted transfer into another link, and holds its value otherwise.
- R8: On the edge after a fault, `fault_kind_o` and `fault_addr_o` capture the cause and the address: 1 for a read (data address), 2 for a write (data address), 3 for a transfer (target), 4 for the PC (PC value). Priority is PC, then data, then transfer. Both registers reset to 0 and hold until the next fault.
- R9: `fault_o` stays low in any cycle in which neither `dacc_vld_i` nor `xfer_vld_i` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_base_i | input | 8*32 | Lower bound of each region |
| cfg_limit_i | input | 8*32 | Upper bound of each region |
| cfg_link_i | input | 8*3 | Link number of each region |
| cfg_code_mask_i | input | 8 | Bit l set: link l is a code link |
| cfg_perm_i | input | 128 | Permission codes per code link and data link |
| cfg_entry_i | input | 16*32 | Entry addresses, two per link |
| cfg_entry_vld_i | input | 16 | Valid bit per entry slot |
| pc_i | input | 32 | Current program counter |
| dacc_vld_i | input | 1 | Data access present |
| dacc_we_i | input | 1 | Data access is a write |
| dacc_addr_i | input | 32 | Data address |
| xfer_vld_i | input | 1 | Call, branch or return present |
| xfer_tgt_i | input | 32 | Transfer target address |
| fault_o | output | 1 | Violation in this cycle |
| fault_kind_o | output | 3 | Last fault cause |
| fault_addr_o | output | 32 | Last faulting address |
| active_link_o | output | 3 | Link of the current PC |
| stack_sel_o | output | 3 | Selected hardware stack |

## Verification
The properties assume that the configuration inputs do not change while requests are in flight, and that request inputs are settled before the clock edge. They do not assume that PC, data and transfer requests are mutually exclusive. The bench loads the configuration once during reset and never touches it again. It changes the request inputs only on falling edges. Its sweeps deliberately present bad PCs and overlapping regions, and at times a data request and a transfer in the same cycle, so that the priority rules are exercised.

// File: rtl/tg_pkg.sv
package tg_pkg;
  typedef enum logic [2:0] {
    FK_NONE  = 3'd0,
    FK_READ  = 3'd1,
    FK_WRITE = 3'd2,
    FK_XFER  = 3'd3,
    FK_PC    = 3'd4
  } fault_kind_e;
endpackage

// File: rtl/tg_region_lookup.sv
module tg_region_lookup #(
  parameter int NUM_REGIONS = 8,
  parameter int ADDR_W      = 32,
  parameter int LINK_W      = 3
) (
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [NUM_REGIONS*ADDR_W-1:0] base_i,
  input  logic [NUM_REGIONS*ADDR_W-1:0] limit_i,
  input  logic [NUM_REGIONS*LINK_W-1:0] link_i,
  output logic                          hit_o,
  output logic [LINK_W-1:0]             link_o
);
  logic [NUM_REGIONS-1:0] match;

  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_cmp
    assign match[r] = (addr_i >= base_i[r*ADDR_W +: ADDR_W]) &&
                      (addr_i <= limit_i[r*ADDR_W +: ADDR_W]);
  end

  // lowest index overrides: scan from the top down
  always_comb begin
    hit_o  = 1'b0;
    link_o = '0;
    for (int r = NUM_REGIONS - 1; r >= 0; r--) begin
      if (match[r]) begin
        hit_o  = 1'b1;
        link_o = link_i[r*LINK_W +: LINK_W];
      end
    end
  end
endmodule

// File: rtl/tg_perm_check.sv
module tg_perm_check #(
  parameter int LINK_W = 3,
  localparam int NUM_LINKS = 1 << LINK_W
) (
  input  logic [LINK_W-1:0]              code_link_i,
  input  logic [LINK_W-1:0]              data_link_i,
  input  logic                           we_i,
  input  logic [NUM_LINKS*NUM_LINKS*2-1:0] perm_i,
  output logic                           allow_o
);
  logic [2*LINK_W:0] pidx;
  logic [1:0]        code;

  assign pidx    = {code_link_i, data_link_i, 1'b0};
  assign code    = perm_i[pidx +: 2];
  assign allow_o = we_i ? code[1] : code[0];
endmodule

// File: rtl/tg_entry_check.sv
module tg_entry_check #(
  parameter int LINK_W      = 3,
  parameter int NUM_ENTRIES = 2,
  parameter int ADDR_W      = 32,
  localparam int NUM_LINKS  = 1 << LINK_W,
  localparam int SLICE_W    = NUM_ENTRIES * ADDR_W
) (
  input  logic [ADDR_W-1:0]                      tgt_i,
  input  logic [LINK_W-1:0]                      link_i,
  input  logic [NUM_LINKS*SLICE_W-1:0]           entry_i,
  input  logic [NUM_LINKS*NUM_ENTRIES-1:0]       entry_vld_i,
  output logic                                   hit_o
);
  logic [SLICE_W-1:0]     slots;
  logic [NUM_ENTRIES-1:0] vlds;
  logic [NUM_ENTRIES-1:0] slot_hit;

  assign slots = entry_i[int'(link_i)*SLICE_W +: SLICE_W];
  assign vlds  = entry_vld_i[int'(link_i)*NUM_ENTRIES +: NUM_ENTRIES];

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_slot
    assign slot_hit[e] = vlds[e] && (slots[e*ADDR_W +: ADDR_W] == tgt_i);
  end

  assign hit_o = |slot_hit;
endmodule

// File: rtl/thread_guard.sv
module thread_guard
  import tg_pkg::*;
#(
  parameter int NUM_REGIONS = 8,
  parameter int ADDR_W      = 32,
  parameter int LINK_W      = 3,
  parameter int NUM_ENTRIES = 2,
  localparam int NUM_LINKS  = 1 << LINK_W
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic [NUM_REGIONS*ADDR_W-1:0]        cfg_base_i,
  input  logic [NUM_REGIONS*ADDR_W-1:0]        cfg_limit_i,
  input  logic [NUM_REGIONS*LINK_W-1:0]        cfg_link_i,
  input  logic [NUM_LINKS-1:0]                 cfg_code_mask_i,
  input  logic [NUM_LINKS*NUM_LINKS*2-1:0]     cfg_perm_i,
  input  logic [NUM_LINKS*NUM_ENTRIES*ADDR_W-1:0] cfg_entry_i,
  input  logic [NUM_LINKS*NUM_ENTRIES-1:0]     cfg_entry_vld_i,
  input  logic [ADDR_W-1:0]                    pc_i,
  input  logic                                 dacc_vld_i,
  input  logic                                 dacc_we_i,
  input  logic [ADDR_W-1:0]                    dacc_addr_i,
  input  logic                                 xfer_vld_i,
  input  logic [ADDR_W-1:0]                    xfer_tgt_i,
  output logic                                 fault_o,
  output logic [2:0]                           fault_kind_o,
  output logic [ADDR_W-1:0]                    fault_addr_o,
  output logic [LINK_W-1:0]                    active_link_o,
  output logic [LINK_W-1:0]                    stack_sel_o
);
  logic              pc_hit, d_hit, t_hit;
  logic [LINK_W-1:0] pc_link, d_link, t_link;
  logic              pc_ok, d_allow, entry_hit, xfer_ok;
  logic              pc_bad, data_bad, xfer_bad, xfer_cross;
  fault_kind_e       kind_d, kind_q;
  logic [ADDR_W-1:0] addr_d, addr_q;
  logic [LINK_W-1:0] stack_q;

  tg_region_lookup #(.NUM_REGIONS(NUM_REGIONS), .ADDR_W(ADDR_W), .LINK_W(LINK_W)) u_pc_lk (
    .addr_i(pc_i), .base_i(cfg_base_i), .limit_i(cfg_limit_i), .link_i(cfg_link_i),
    .hit_o(pc_hit), .link_o(pc_link)
  );

  tg_region_lookup #(.NUM_REGIONS(NUM_REGIONS), .ADDR_W(ADDR_W), .LINK_W(LINK_W)) u_data_lk (
    .addr_i(dacc_addr_i), .base_i(cfg_base_i), .limit_i(cfg_limit_i), .link_i(cfg_link_i),
    .hit_o(d_hit), .link_o(d_link)
  );

  tg_region_lookup #(.NUM_REGIONS(NUM_REGIONS), .ADDR_W(ADDR_W), .LINK_W(LINK_W)) u_tgt_lk (
    .addr_i(xfer_tgt_i), .base_i(cfg_base_i), .limit_i(cfg_limit_i), .link_i(cfg_link_i),
    .hit_o(t_hit), .link_o(t_link)
  );

  tg_perm_check #(.LINK_W(LINK_W)) u_perm (
    .code_link_i(pc_link), .data_link_i(d_link), .we_i(dacc_we_i),
    .perm_i(cfg_perm_i), .allow_o(d_allow)
  );

  tg_entry_check #(.LINK_W(LINK_W), .NUM_ENTRIES(NUM_ENTRIES), .ADDR_W(ADDR_W)) u_entry (
    .tgt_i(xfer_tgt_i), .link_i(t_link), .entry_i(cfg_entry_i),
    .entry_vld_i(cfg_entry_vld_i), .hit_o(entry_hit)
  );

  assign pc_ok      = pc_hit && cfg_code_mask_i[pc_link];
  assign xfer_cross = t_link != pc_link;
  assign xfer_ok    = t_hit && cfg_code_mask_i[t_link] && (!xfer_cross || entry_hit);

  assign pc_bad   = (dacc_vld_i || xfer_vld_i) && !pc_ok;
  assign data_bad = dacc_vld_i && pc_ok && !(d_hit && d_allow);
  assign xfer_bad = xfer_vld_i && pc_ok && !xfer_ok;
  assign fault_o  = pc_bad || data_bad || xfer_bad;

  always_comb begin
    kind_d = kind_q;
    addr_d = addr_q;
    if (pc_bad) begin
      kind_d = FK_PC;
      addr_d = pc_i;
    end else if (data_bad) begin
      kind_d = dacc_we_i ? FK_WRITE : FK_READ;
      addr_d = dacc_addr_i;
    end else if (xfer_bad) begin
      kind_d = FK_XFER;
      addr_d = xfer_tgt_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_q  <= FK_NONE;
      addr_q  <= '0;
      stack_q <= '0;
    end else begin
      kind_q <= kind_d;
      addr_q <= addr_d;
      if (xfer_vld_i && pc_ok && xfer_ok && xfer_cross) stack_q <= t_link;
    end
  end

  assign fault_kind_o  = kind_q;
  assign fault_addr_o  = addr_q;
  assign active_link_o = pc_link;
  assign stack_sel_o   = stack_q;
endmodule

// File: rtl/tg_checker.sv
module tg_checker #(
  parameter int ADDR_W = 32,
  parameter int LINK_W = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              dacc_vld_i,
  input logic              xfer_vld_i,
  input logic              fault_o,
  input logic [2:0]        fault_kind_o,
  input logic [ADDR_W-1:0] fault_addr_o,
  input logic [LINK_W-1:0] stack_sel_o,
  input logic              pc_bad,
  input logic              xfer_bad
);
  p_quiet_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dacc_vld_i || xfer_vld_i) |-> !fault_o);

  p_latch_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |=> fault_kind_o != 3'd0);

  p_latch_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fault_o |=> $stable(fault_kind_o) && $stable(fault_addr_o));

  p_kind_legal_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_kind_o <= 3'd4);

  p_pc_first_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_bad |=> fault_kind_o == 3'd4);

  p_stack_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xfer_vld_i |=> $stable(stack_sel_o));

  p_stack_denied_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_vld_i && (xfer_bad || pc_bad)) |=> $stable(stack_sel_o));
endmodule

bind thread_guard tg_checker #(.ADDR_W(ADDR_W), .LINK_W(LINK_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .dacc_vld_i(dacc_vld_i), .xfer_vld_i(xfer_vld_i),
  .fault_o(fault_o), .fault_kind_o(fault_kind_o), .fault_addr_o(fault_addr_o),
  .stack_sel_o(stack_sel_o), .pc_bad(pc_bad), .xfer_bad(xfer_bad)
);

// File: tb/thread_guard_tb.sv
module thread_guard_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [255:0] cfg_base, cfg_limit;
  logic [23:0]  cfg_link;
  logic [7:0]   cfg_code_mask;
  logic [127:0] cfg_perm;
  logic [511:0] cfg_entry;
  logic [15:0]  cfg_entry_vld;
  logic [31:0]  pc, dacc_addr, xfer_tgt;
  logic         dacc_vld, dacc_we, xfer_vld;
  logic         fault;
  logic [2:0]   fault_kind;
  logic [31:0]  fault_addr;
  logic [2:0]   active_link, stack_sel;

  int checks = 0;
  int fails = 0;
  int exp_kind = 0;
  int exp_addr = 0;
  int exp_stack = 0;

  thread_guard u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_base_i(cfg_base), .cfg_limit_i(cfg_limit), .cfg_link_i(cfg_link),
    .cfg_code_mask_i(cfg_code_mask), .cfg_perm_i(cfg_perm),
    .cfg_entry_i(cfg_entry), .cfg_entry_vld_i(cfg_entry_vld),
    .pc_i(pc), .dacc_vld_i(dacc_vld), .dacc_we_i(dacc_we), .dacc_addr_i(dacc_addr),
    .xfer_vld_i(xfer_vld), .xfer_tgt_i(xfer_tgt),
    .fault_o(fault), .fault_kind_o(fault_kind), .fault_addr_o(fault_addr),
    .active_link_o(active_link), .stack_sel_o(stack_sel)
  );

  task automatic chk(int act, int exp, string tag);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // R1 model: regions 0..6 tile 256-byte blocks, region 7 overlaps from 0x80 to 0x7FF
  function automatic void look(input int a, output bit h, output int lk);
    h = 0; lk = 0;
    for (int r = 7; r >= 0; r--) begin
      int lo = (r == 7) ? 32'h80 : r * 256;
      int hi = (r == 7) ? 32'h7FF : r * 256 + 255;
      if (a >= lo && a <= hi) begin h = 1; lk = r; end
    end
  endfunction

  task automatic step(int p, bit dv, bit we, int da, bit xv, int tg, string ftag);
    bit ph, dh, th, pc_ok, allow, ent_ok, xok, pbad, dbad, xbad;
    int pl, dl, tl, code;
    look(p, ph, pl);
    look(da, dh, dl);
    look(tg, th, tl);
    pc_ok  = ph && (pl < 4);
    code   = (pl + dl) & 3;                 // R3 table content
    allow  = we ? code[1] : code[0];
    ent_ok = (tg == tl * 256 + 16) || ((tg == tl * 256 + 32) && (tl % 2 == 0));
    xok    = th && (tl < 4) && ((tl == pl) || ent_ok);
    pbad   = (dv || xv) && !pc_ok;
    dbad   = dv && pc_ok && !(dh && allow);
    xbad   = xv && pc_ok && !xok;
    pc = p; dacc_vld = dv; dacc_we = we; dacc_addr = da; xfer_vld = xv; xfer_tgt = tg;
    #5;
    chk(int'(fault), int'(pbad || dbad || xbad), ftag);
    chk(int'(active_link), ph ? pl : 0, "R2 active_link");
    if (pbad)      begin exp_kind = 4; exp_addr = p; end
    else if (dbad) begin exp_kind = we ? 2 : 1; exp_addr = da; end
    else if (xbad) begin exp_kind = 3; exp_addr = tg; end
    if (xv && pc_ok && xok && tl != pl) exp_stack = tl;
    @(posedge clk);
    #5;
    chk(int'(fault_kind), exp_kind, "R8 kind");
    chk(int'(fault_addr), exp_addr, "R8 addr");
    chk(int'(stack_sel), exp_stack, "R7 stack");
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int r = 0; r < 8; r++) begin
      cfg_base[r*32 +: 32]  = (r == 7) ? 32'h80 : r * 256;
      cfg_limit[r*32 +: 32] = (r == 7) ? 32'h7FF : r * 256 + 255;
      cfg_link[r*3 +: 3]    = 3'(r);
    end
    cfg_code_mask = 8'h0F;
    for (int c = 0; c < 8; c++)
      for (int d = 0; d < 8; d++)
        cfg_perm[(c*8+d)*2 +: 2] = 2'((c + d) & 3);
    for (int l = 0; l < 8; l++)
      for (int e = 0; e < 2; e++) begin
        cfg_entry[(l*2+e)*32 +: 32] = l * 256 + 16 * (e + 1);
        cfg_entry_vld[l*2+e]        = (e == 0) || (l % 2 == 0);
      end
    pc = 32'h900; dacc_vld = 0; dacc_we = 0; dacc_addr = 0; xfer_vld = 0; xfer_tgt = 0;
    repeat (3) @(negedge clk);
    // reset state (R7, R8) and idle with an unmapped PC (R9)
    chk(int'(fault_kind), 0, "R8 reset kind");
    chk(int'(fault_addr), 0, "R8 reset addr");
    chk(int'(stack_sel), 0, "R7 reset stack");
    chk(int'(fault), 0, "R9 idle");
    rst_n = 1'b1;
    @(negedge clk);
    step(32'h900, 0, 0, 0, 0, 0, "R9 idle no fault");
    // R1: 0x84 overlaps regions 0 and 7; region 0 wins
    step(32'h84, 0, 0, 0, 0, 0, "R1 priority idle");
    chk(int'(active_link), 0, "R1 overlap picks lowest");
    // R3 / R4 data sweep over PCs in code links, a data link and unmapped space
    for (int pi = 0; pi < 6; pi++) begin
      int p = (pi < 4) ? pi * 256 + 4 : (pi == 4 ? 32'h404 : 32'h900);
      for (int a = 0; a <= 32'h900; a += 32'h40)
        for (int w = 0; w < 2; w++)
          step(p, 1, w[0], a, 0, 0, (pi < 4) ? "R4 data" : "R2 pc fault");
    end
    // R5 / R6 / R7 transfer sweep
    for (int pi = 0; pi < 9; pi++) begin
      int p = (pi < 8) ? pi * 256 + 4 : 32'h900;
      for (int ti = 0; ti < 34; ti++) begin
        int t;
        if (ti < 32) t = (ti / 4) * 256 + ((ti % 4 == 3) ? 4 : 16 * (ti % 4 + 1));
        else t = (ti == 32) ? 32'h900 : 32'h85C;
        step(p, 0, 0, 0, 1, t, (pi < 8 && (t / 256) == pi) ? "R5 same link" : "R6 entry");
      end
    end
    // R8 priority: bad read together with a bad transfer -> read recorded
    step(32'h004, 1, 0, 32'h880, 1, 32'h230, "R8 data over xfer");
    chk(int'(fault_kind), 1, "R8 data over xfer kind");
    // R8 priority: bad PC beats a bad write
    step(32'h404, 1, 1, 32'h880, 0, 0, "R8 pc over data");
    chk(int'(fault_kind), 4, "R8 pc over data kind");
    step(32'h004, 0, 0, 0, 0, 0, "R9 final idle");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule